// File: doc/BRIEF.md
# Compare and Predicated Write-Back Stage

This block is the last stage of an in-order pipeline that has no operand forwarding and no interlocks, together with the register file that the register-fetch stage reads. Each cycle the execute stage may hand over one instruction. That instruction carries an operation code, a destination index, a write-enable flag, a result value and the two operand values that were fetched for it. Pass operations write the result as it is. Compare operations build a full-width mask from the two operands: every bit is one when the condition holds and every bit is zero when it does not. A skip-if-false operation tests its first operand. If that operand is zero, the operation arms a one-shot flag, and the flag cancels the register write of the next instruction that is accepted.

All instructions have the same latency, so they reach this stage in program order, at most one per cycle. The input uses a valid/ready handshake. An instruction is taken on a rising clock edge only when `in_valid` and `in_ready` are both high. `in_ready` is the inverse of the `stall` pin, which the cache logic raises on a miss. While `in_ready` is low, upstream must hold its instruction unchanged. During that time no register is written and the skip flag keeps its value. The two read ports are combinational and have no bypass, so a read returns only values that were written on earlier edges.

Top module: `cwb_stage`

## Requirements
- R1: The register file holds 16 registers of WIDTH bits each (default 32), and reset clears every register to zero. Each of the two read ports returns the register selected by its address combinationally.
- R2: Opcode 0 (pass) with `in_we` high writes `in_result` to register `in_rd`. With `in_we` low, no register changes.
- R3: Opcodes 1 (equal), 2 (not equal), 3 (signed less-than, a < b) and 4 (unsigned less-than, a < b) compare `in_opa` with `in_opb`. When `in_we` is high they write all ones to `in_rd` if the condition is true and all zeros if it is false.
- R4: Opcode 5 (skip-if-false) never writes a register, whatever the value of `in_we`. It arms the skip flag when `in_opa` is all zeros, and it leaves the flag clear when `in_opa` has any nonzero value.
- R5: An armed skip flag cancels the write of the next accepted instruction and is cleared by that instruction, whether or not that instruction had `in_we` set. A cancelled skip-if-false does not arm the flag again.
- R6: A cycle with `in_valid` low writes nothing and leaves the skip flag as it was.
- R7: While `stall` is high, `in_ready` is low, no register is written and the skip flag holds its value.
- R8: A read of a register in the same cycle as a write to it returns the old value. The new value appears after the clock edge.
- R9: Register 0 is an ordinary register that can be written and read back. It is not tied to zero.
- R10: Opcodes 6 and 7 write no register and do not arm the skip flag. They still consume a pending skip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall | input | 1 | Cache-miss freeze of the stage |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | Stage can accept, equal to not stall |
| in_op | input | 3 | Operation code (0 pass, 1..4 compares, 5 skip-if-false) |
| in_we | input | 1 | Instruction requests a register write |
| in_rd | input | 4 | Destination register index |
| in_result | input | WIDTH | Result value for pass operations |
| in_opa | input | WIDTH | First operand (compare left side, skip test) |
| in_opb | input | WIDTH | Second operand (compare right side) |
| rd_addr_a | input | 4 | Read port A address |
| rd_data_a | output | WIDTH | Read port A data |
| rd_addr_b | input | 4 | Read port B address |
| rd_data_b | output | WIDTH | Read port B data |

## Verification
The compares are swept over a grid of 16 by 16 operand values in an 8-bit build, using all four compare codes. The grid includes 0, 1, 0x7F, 0x80, 0xFE and 0xFF, so that equal operands, neighbouring values, and pairs whose signed and unsigned orderings disagree all occur. Skip-if-false is tried with zero and with nonzero operands, each followed by a write with `in_we` high and by one with `in_we` low. This separates a flag that cancels exactly one write from one that lingers or never arms. Bubbles, stalls, a skip-if-false that is itself cancelled, and a read in the same cycle as a write are each placed so that a wrong flag update or a read bypass shows up as a different register value.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int unsigned NREGS = 16;
  localparam int unsigned AW    = $clog2(NREGS);

  typedef enum logic [2:0] {
    OP_PASS  = 3'd0,
    OP_EQ    = 3'd1,
    OP_NE    = 3'd2,
    OP_LT    = 3'd3,
    OP_LTU   = 3'd4,
    OP_SKIPF = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } op_e;
endpackage

// File: rtl/cwb_cmp_unit.sv
module cwb_cmp_unit
  import cwb_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  op_e              op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             is_cmp,
  output logic [WIDTH-1:0] mask
);
  logic hit;

  always_comb begin
    is_cmp = 1'b1;
    unique case (op)
      OP_EQ:   hit = (a == b);
      OP_NE:   hit = (a != b);
      OP_LT:   hit = ($signed(a) < $signed(b));
      OP_LTU:  hit = (a < b);
      default: begin
        hit    = 1'b0;
        is_cmp = 1'b0;
      end
    endcase
    mask = {WIDTH{hit}};
  end

  // R3: the mask is always a full-width all-ones or all-zeros word
  always_comb begin
    a_r3_mask_form: assert ((mask == '0) || (mask == '1));
  end
endmodule

// File: rtl/cwb_skip_ctl.sv
module cwb_skip_ctl
  import cwb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  op_e  op,
  input  logic opa_zero,
  output logic skip_q
);
  logic skip_d;

  always_comb begin
    skip_d = skip_q;
    if (fire) begin
      if (skip_q) skip_d = 1'b0;
      else        skip_d = (op == OP_SKIPF) && opa_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) skip_q <= 1'b0;
    else        skip_q <= skip_d;
  end

  // R5: an armed flag lasts for exactly one accepted instruction
  a_r5_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && fire) |=> !skip_q);
  // R6 / R7: without an accepted instruction the flag holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(skip_q));
endmodule

// File: rtl/cwb_regfile.sv
module cwb_regfile #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem[i] <= '0;
      else if (we && (waddr == AW'(i)))    mem[i] <= wdata;
    end

    // R2: an entry changes only through a write addressed to it
    a_r2_entry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (waddr == AW'(i))) |=> $stable(mem[i]));
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/cwb_stage.sv
module cwb_stage
  import cwb_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic             in_we,
  input  logic [3:0]       in_rd,
  input  logic [WIDTH-1:0] in_result,
  input  logic [WIDTH-1:0] in_opa,
  input  logic [WIDTH-1:0] in_opb,
  input  logic [3:0]       rd_addr_a,
  output logic [WIDTH-1:0] rd_data_a,
  input  logic [3:0]       rd_addr_b,
  output logic [WIDTH-1:0] rd_data_b
);
  op_e              op;
  logic             fire;
  logic             skip_q;
  logic             is_cmp;
  logic [WIDTH-1:0] mask;
  logic             rf_we;
  logic [WIDTH-1:0] rf_wdata;

  assign op       = op_e'(in_op);
  assign in_ready = !stall;
  assign fire     = in_valid && in_ready;

  cwb_cmp_unit #(.WIDTH(WIDTH)) u_cmp (
    .op     (op),
    .a      (in_opa),
    .b      (in_opb),
    .is_cmp (is_cmp),
    .mask   (mask)
  );

  cwb_skip_ctl u_skip (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .op       (op),
    .opa_zero (in_opa == '0),
    .skip_q   (skip_q)
  );

  always_comb begin
    rf_wdata = is_cmp ? mask : in_result;
    rf_we    = fire && in_we && !skip_q && (is_cmp || (op == OP_PASS));
  end

  cwb_regfile #(.WIDTH(WIDTH), .DEPTH(NREGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (in_rd),
    .wdata   (rf_wdata),
    .raddr_a (rd_addr_a),
    .rdata_a (rd_data_a),
    .raddr_b (rd_addr_b),
    .rdata_b (rd_data_b)
  );

  // R5: a pending skip blocks the write of the accepted instruction
  a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && fire) |-> !rf_we);
  // R7: a frozen stage never writes
  a_r7_no_write_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !rf_we);
  // R4: skip-if-false never reaches the register file
  a_r4_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_op == 3'd5)) |-> !rf_we);
endmodule

// File: tb/sim_cwb_stage.sv
`timescale 1ns/1ps
module sim_cwb_stage;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, stall = 0, in_valid = 0, in_we = 0;
  logic in_ready;
  logic [2:0] in_op = 0;
  logic [3:0] in_rd = 0, rd_addr_a = 0, rd_addr_b = 0;
  logic [W-1:0] in_result = 0, in_opa = 0, in_opb = 0, rd_data_a, rd_data_b;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cwb_stage #(.WIDTH(W)) u0 (.*);

  task automatic chk(input string tag, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic issue(input int op, input bit we, input int rd, input int res,
                       input int a, input int b);
    @(negedge clk);
    in_valid = 1; in_op = 3'(op); in_we = we; in_rd = 4'(rd);
    in_result = W'(res); in_opa = W'(a); in_opb = W'(b);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic peek(input int addr, output int v);
    rd_addr_a = 4'(addr); #1; v = int'(rd_data_a);
  endtask

  function automatic int gridv(int i);
    case (i)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h7F; 3: return 8'h80;
      4: return 8'hFF; 5: return 8'hFE; 6: return 8'h81; 7: return 8'h7E;
      default: return (i * 37) & 8'hFF;
    endcase
  endfunction

  function automatic int sx(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  initial begin
    #(20ns * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int v;
    #35 rst_n = 1;
    // R1: reset clears all 16 registers
    for (int r = 0; r < 16; r++) begin peek(r, v); chk("R1 reset", v, 0); end
    chk("R7 ready idle", int'(in_ready), 1);

    // R2 / R9: pass writes, including register 0
    issue(0, 1, 0, 8'h5A, 0, 0); peek(0, v); chk("R9 reg0 write", v, 8'h5A);
    issue(0, 1, 15, 8'hC3, 0, 0); peek(15, v); chk("R2 pass", v, 8'hC3);
    issue(0, 0, 15, 8'h11, 0, 0); peek(15, v); chk("R2 we low", v, 8'hC3);

    // R3: compare sweep
    for (int ia = 0; ia < 16; ia++)
      for (int ib = 0; ib < 16; ib++)
        for (int op = 1; op <= 4; op++) begin
          int a = gridv(ia), b = gridv(ib), rd = (ia + ib + op) & 15, e;
          case (op)
            1: e = (a == b); 2: e = (a != b);
            3: e = (sx(a) < sx(b)); default: e = (a < b);
          endcase
          issue(op, 1, rd, 8'h33, a, b); peek(rd, v);
          chk("R3 compare", v, e ? 8'hFF : 8'h00);
        end

    // R4: skip with true operand does not arm and does not write
    issue(0, 1, 2, 8'h20, 0, 0);
    issue(5, 1, 2, 8'h99, 8'h40, 0); peek(2, v); chk("R4 no write", v, 8'h20);
    issue(0, 1, 3, 8'h31, 0, 0); peek(3, v); chk("R4 true no arm", v, 8'h31);

    // R5: false skip cancels exactly one write
    issue(5, 0, 0, 0, 0, 0);
    issue(0, 1, 3, 8'h77, 0, 0); peek(3, v); chk("R5 cancelled", v, 8'h31);
    issue(0, 1, 3, 8'h78, 0, 0); peek(3, v); chk("R5 one shot", v, 8'h78);
    // R5: flag consumed even by an instruction with we low
    issue(5, 0, 0, 0, 0, 0);
    issue(0, 0, 3, 8'h01, 0, 0);
    issue(0, 1, 3, 8'h79, 0, 0); peek(3, v); chk("R5 consumed by we0", v, 8'h79);
    // R5: cancelled skip does not re-arm
    issue(5, 0, 0, 0, 0, 0);
    issue(5, 0, 0, 0, 0, 0);
    issue(0, 1, 3, 8'h7A, 0, 0); peek(3, v); chk("R5 no rearm", v, 8'h7A);

    // R6: bubbles keep the flag
    issue(5, 0, 0, 0, 0, 0);
    @(negedge clk); in_we = 1; in_rd = 4; in_result = 8'hEE; in_op = 0;
    @(posedge clk); #1; peek(4, v); chk("R6 bubble no write", v, 0);
    issue(0, 1, 3, 8'h7B, 0, 0); peek(3, v); chk("R6 flag kept", v, 8'h7A);

    // R7: stall freezes writes and flag
    issue(5, 0, 0, 0, 0, 0);
    @(negedge clk); stall = 1; #1; chk("R7 ready low", int'(in_ready), 0);
    in_valid = 1; in_op = 0; in_we = 1; in_rd = 5; in_result = 8'h55;
    @(posedge clk); #1; peek(5, v); chk("R7 no write", v, 0);
    @(negedge clk); stall = 0; in_valid = 0;
    issue(0, 1, 5, 8'h56, 0, 0); peek(5, v); chk("R7 flag held", v, 0);
    issue(0, 1, 5, 8'h57, 0, 0); peek(5, v); chk("R7 resume", v, 8'h57);

    // R10: reserved codes write nothing, consume skip, do not arm
    issue(6, 1, 6, 8'h66, 0, 0); peek(6, v); chk("R10 no write", v, 0);
    issue(7, 1, 6, 8'h67, 0, 0);
    issue(0, 1, 6, 8'h68, 0, 0); peek(6, v); chk("R10 no arm", v, 8'h68);
    issue(5, 0, 0, 0, 0, 0);
    issue(7, 0, 0, 0, 0, 0);
    issue(0, 1, 6, 8'h69, 0, 0); peek(6, v); chk("R10 consumes", v, 8'h69);

    // R8: same-cycle read sees old value
    @(negedge clk);
    in_valid = 1; in_op = 0; in_we = 1; in_rd = 7; in_result = 8'hA7;
    rd_addr_b = 7; #1; chk("R8 old value", int'(rd_data_b), 0);
    @(posedge clk); #1; in_valid = 0; chk("R8 new value", int'(rd_data_b), 8'hA7);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule